// File: doc/BRIEF.md
# RMII Receive Decoder

This block sits on the MAC side of a reduced media-independent receive link. On every cycle of the 50 MHz reference clock it registers the combined carrier/valid pin, the two-bit receive data bus and the receive error pin. It then recovers carrier sense and receive-data-valid as two separate signals. The combined pin is read only at nibble boundaries. When it drops on the first dibit of a nibble, the carrier has ended. When it stays high on the second dibit, the PHY still has buffered bits to deliver.

Dibits are paired into nibbles. The nibble phase is taken from the first non-zero dibit after the carrier rises. Nibbles are packed into bytes, low nibble first, once the start-of-frame delimiter has been found. Each byte is presented with a one-cycle valid strobe, and the first byte carries a start-of-frame flag. A separate end-of-frame pulse carries an error flag and an alignment flag. A speed input selects 100 Mb/s, where every reference clock carries a new dibit, or 10 Mb/s, where each dibit is held for ten clocks and is sampled once.

Top module: `rmii_rx_decoder`

## Requirements
- R1: While rst_ni is low and in the first cycle after it rises, crs_o, rx_dv_o, byte_valid_o, sof_o, eof_o, frame_err_o and align_err_o are all low.
- R2: With speed_100_i high, one dibit is taken every clock. With speed_100_i low, each dibit is held for ten clocks, counted from the clock in which crs_dv_i first rises. Only the fifth clock of each ten is sampled, so rxd_i may hold any value in the other nine.
- R3: When crs_dv_i rises from idle, crs_o and rx_dv_o both rise together, two clocks later in 100 Mb/s mode.
- R4: After carrier rises, dibits of 00 are discarded. The first 01 dibit is taken as the first (low) dibit of a nibble, and the dibits that follow alternate between second and first position.
- R5: crs_dv_i low on a first-position dibit drops crs_o, and crs_o stays low for the rest of the event. rx_dv_o stays high, and the nibble is kept as data, whenever crs_dv_i is high on its second-position dibit.
- R6: crs_dv_i low on a second-position dibit, or on any sampled dibit before the nibble phase is known, ends the event. rx_dv_o and crs_o go low, and that nibble is discarded.
- R7: The delimiter is a nibble of value 0xD, which is dibit 01 followed by dibit 11. Each later pair of nibbles forms byte_o = {second nibble, first nibble}, with rxd_i[1:0] of the earliest dibit in bits [1:0]. byte_valid_o pulses for one cycle per byte, and sof_o is high with the first byte only.
- R8: For an event in which the delimiter was found, eof_o pulses once, one clock after rx_dv_o falls, and never in the same cycle as byte_valid_o. Events without a delimiter produce no eof_o and no bytes.
- R9: align_err_o is high with eof_o exactly when an odd number of nibbles followed the delimiter, and is low at all other times.
- R10: frame_err_o is high with eof_o exactly when rx_er_i was high on any sampled dibit of that event, and is low at all other times.
- R11: crs_o is never high while rx_dv_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 50 MHz reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| speed_100_i | input | 1 | 1 selects 100 Mb/s, 0 selects 10 Mb/s |
| crs_dv_i | input | 1 | Combined carrier sense / data valid from the PHY |
| rxd_i | input | 2 | Receive dibit |
| rx_er_i | input | 1 | Receive error from the PHY |
| crs_o | output | 1 | Recovered carrier sense |
| rx_dv_o | output | 1 | Recovered receive data valid |
| byte_o | output | 8 | Received byte |
| byte_valid_o | output | 1 | byte_o valid strobe |
| sof_o | output | 1 | First byte after the delimiter |
| eof_o | output | 1 | End-of-frame pulse |
| frame_err_o | output | 1 | Receive error seen during the frame (valid with eof_o) |
| align_err_o | output | 1 | Odd nibble count at end of frame (valid with eof_o) |

## Verification
The hardest situation to reach is the tail in which the carrier has already dropped but buffered data keeps arriving. Here the combined pin toggles once per nibble, and the decoder must keep data-valid high through the low half-periods. The bench sets the last two nibbles of a frame to this toggling form and checks them at every speed, byte count and odd or even nibble count. In 10 Mb/s mode it also puts inverted data on the nine unsampled clocks of every dibit. This catches a sample point that drifts by a single clock.

// File: rtl/rmii_rx_pkg.sv
`timescale 1ns/1ps
package rmii_rx_pkg;
  localparam int unsigned NIB_W = 4;
  localparam logic [1:0] DIBIT_LOCK = 2'b01;
  localparam logic [NIB_W-1:0] SFD_NIB = 4'hD;

  typedef enum logic [1:0] {LNK_IDLE, LNK_HUNT, LNK_LOCK} lnk_state_e;
  typedef enum logic {ASM_PRE, ASM_DATA} asm_state_e;
endpackage

// File: rtl/rmii_rx_sampler.sv
`timescale 1ns/1ps
module rmii_rx_sampler #(
  parameter int unsigned SLOW_DIV = 10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       speed_100_i,
  input  logic       crs_dv_i,
  input  logic [1:0] rxd_i,
  input  logic       rx_er_i,
  input  logic       busy_i,
  output logic       s_crs_o,
  output logic [1:0] s_rxd_o,
  output logic       s_er_o,
  output logic       stb_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s_crs_o <= 1'b0;
      s_rxd_o <= '0;
      s_er_o  <= 1'b0;
    end else begin
      s_crs_o <= crs_dv_i;
      s_rxd_o <= rxd_i;
      s_er_o  <= rx_er_i;
    end
  end

  generate
    if (SLOW_DIV > 1) begin : g_div
      localparam int unsigned CNT_W = $clog2(SLOW_DIV);
      localparam logic [CNT_W-1:0] MID  = CNT_W'(SLOW_DIV / 2 - 1);
      localparam logic [CNT_W-1:0] LAST = CNT_W'(SLOW_DIV - 1);
      logic [CNT_W-1:0] cnt_q;

      // phase counter restarts at every carrier rise from idle
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                   cnt_q <= '0;
        else if (!(s_crs_o || busy_i)) cnt_q <= '0;
        else if (cnt_q == LAST)        cnt_q <= '0;
        else                           cnt_q <= cnt_q + 1'b1;
      end

      assign stb_o = speed_100_i | (cnt_q == MID);
    end else begin : g_nodiv
      assign stb_o = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/rmii_rx_link.sv
`timescale 1ns/1ps
module rmii_rx_link
  import rmii_rx_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             s_crs_i,
  input  logic [1:0]       s_rxd_i,
  input  logic             s_er_i,
  input  logic             stb_i,
  output logic             crs_o,
  output logic             rx_dv_o,
  output logic             busy_o,
  output logic             nib_vld_o,
  output logic [NIB_W-1:0] nib_o,
  output logic             ep_end_o,
  output logic             er_hit_o
);
  lnk_state_e state_q;
  logic       ph_q;   // 0: next dibit is first of nibble
  logic [1:0] lo_q;

  assign busy_o = (state_q != LNK_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= LNK_IDLE;
      ph_q      <= 1'b0;
      lo_q      <= '0;
      crs_o     <= 1'b0;
      rx_dv_o   <= 1'b0;
      nib_vld_o <= 1'b0;
      nib_o     <= '0;
      ep_end_o  <= 1'b0;
      er_hit_o  <= 1'b0;
    end else begin
      nib_vld_o <= 1'b0;
      ep_end_o  <= 1'b0;
      er_hit_o  <= 1'b0;
      unique case (state_q)
        LNK_IDLE: begin
          if (s_crs_i) begin
            crs_o    <= 1'b1;
            rx_dv_o  <= 1'b1;
            er_hit_o <= stb_i & s_er_i;
            if (stb_i && s_rxd_i == DIBIT_LOCK) begin
              lo_q    <= s_rxd_i;
              ph_q    <= 1'b1;
              state_q <= LNK_LOCK;
            end else begin
              state_q <= LNK_HUNT;
            end
          end
        end
        LNK_HUNT: begin
          if (stb_i) begin
            er_hit_o <= s_er_i;
            if (!s_crs_i) begin
              crs_o    <= 1'b0;
              rx_dv_o  <= 1'b0;
              ep_end_o <= 1'b1;
              state_q  <= LNK_IDLE;
            end else if (s_rxd_i == DIBIT_LOCK) begin
              lo_q    <= s_rxd_i;
              ph_q    <= 1'b1;
              state_q <= LNK_LOCK;
            end
          end
        end
        LNK_LOCK: begin
          if (stb_i) begin
            er_hit_o <= s_er_i;
            if (!ph_q) begin
              lo_q <= s_rxd_i;
              ph_q <= 1'b1;
              if (!s_crs_i) crs_o <= 1'b0;
            end else begin
              ph_q <= 1'b0;
              if (s_crs_i) begin
                nib_vld_o <= 1'b1;
                nib_o     <= {s_rxd_i, lo_q};
              end else begin
                crs_o    <= 1'b0;
                rx_dv_o  <= 1'b0;
                ep_end_o <= 1'b1;
                state_q  <= LNK_IDLE;
              end
            end
          end
        end
        default: state_q <= LNK_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rmii_rx_assembler.sv
`timescale 1ns/1ps
module rmii_rx_assembler
  import rmii_rx_pkg::*;
#(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              nib_vld_i,
  input  logic [NIB_W-1:0]  nib_i,
  input  logic              ep_end_i,
  input  logic              er_hit_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              byte_valid_o,
  output logic              sof_o,
  output logic              eof_o,
  output logic              frame_err_o,
  output logic              align_err_o
);
  localparam int unsigned NIBS  = BYTE_W / NIB_W;
  localparam int unsigned IDX_W = (NIBS > 1) ? $clog2(NIBS) : 1;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NIBS - 1);

  asm_state_e        state_q;
  logic [BYTE_W-1:0] sh_q;
  logic [IDX_W-1:0]  idx_q;
  logic              first_q;
  logic              err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ASM_PRE;
      sh_q         <= '0;
      idx_q        <= '0;
      first_q      <= 1'b0;
      err_q        <= 1'b0;
      byte_o       <= '0;
      byte_valid_o <= 1'b0;
      sof_o        <= 1'b0;
      eof_o        <= 1'b0;
      frame_err_o  <= 1'b0;
      align_err_o  <= 1'b0;
    end else begin
      byte_valid_o <= 1'b0;
      sof_o        <= 1'b0;
      eof_o        <= 1'b0;
      frame_err_o  <= 1'b0;
      align_err_o  <= 1'b0;
      if (ep_end_i) begin
        if (state_q == ASM_DATA) begin
          eof_o       <= 1'b1;
          frame_err_o <= err_q | er_hit_i;
          align_err_o <= (idx_q != '0);
        end
        state_q <= ASM_PRE;
        err_q   <= 1'b0;
        idx_q   <= '0;
      end else begin
        if (er_hit_i) err_q <= 1'b1;
        if (nib_vld_i) begin
          if (state_q == ASM_PRE) begin
            if (nib_i == SFD_NIB) begin
              state_q <= ASM_DATA;
              first_q <= 1'b1;
              idx_q   <= '0;
            end
          end else if (idx_q == IDX_LAST) begin
            byte_o       <= {nib_i, sh_q[BYTE_W-1:NIB_W]};
            byte_valid_o <= 1'b1;
            sof_o        <= first_q;
            first_q      <= 1'b0;
            idx_q        <= '0;
          end else begin
            sh_q  <= {nib_i, sh_q[BYTE_W-1:NIB_W]};
            idx_q <= idx_q + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/rmii_rx_decoder.sv
`timescale 1ns/1ps
module rmii_rx_decoder
  import rmii_rx_pkg::*;
#(
  parameter int unsigned SLOW_DIV = 10,
  parameter int unsigned BYTE_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              speed_100_i,
  input  logic              crs_dv_i,
  input  logic [1:0]        rxd_i,
  input  logic              rx_er_i,
  output logic              crs_o,
  output logic              rx_dv_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              byte_valid_o,
  output logic              sof_o,
  output logic              eof_o,
  output logic              frame_err_o,
  output logic              align_err_o
);
  logic             s_crs, s_er, stb, busy;
  logic [1:0]       s_rxd;
  logic             nib_vld, ep_end, er_hit;
  logic [NIB_W-1:0] nib;

  rmii_rx_sampler #(.SLOW_DIV(SLOW_DIV)) u_sampler (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .speed_100_i (speed_100_i),
    .crs_dv_i    (crs_dv_i),
    .rxd_i       (rxd_i),
    .rx_er_i     (rx_er_i),
    .busy_i      (busy),
    .s_crs_o     (s_crs),
    .s_rxd_o     (s_rxd),
    .s_er_o      (s_er),
    .stb_o       (stb)
  );

  rmii_rx_link u_link (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .s_crs_i   (s_crs),
    .s_rxd_i   (s_rxd),
    .s_er_i    (s_er),
    .stb_i     (stb),
    .crs_o     (crs_o),
    .rx_dv_o   (rx_dv_o),
    .busy_o    (busy),
    .nib_vld_o (nib_vld),
    .nib_o     (nib),
    .ep_end_o  (ep_end),
    .er_hit_o  (er_hit)
  );

  rmii_rx_assembler #(.BYTE_W(BYTE_W)) u_asm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .nib_vld_i    (nib_vld),
    .nib_i        (nib),
    .ep_end_i     (ep_end),
    .er_hit_i     (er_hit),
    .byte_o       (byte_o),
    .byte_valid_o (byte_valid_o),
    .sof_o        (sof_o),
    .eof_o        (eof_o),
    .frame_err_o  (frame_err_o),
    .align_err_o  (align_err_o)
  );
endmodule

// File: rtl/rmii_rx_decoder_chk.sv
`timescale 1ns/1ps
module rmii_rx_decoder_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic crs_o,
  input logic rx_dv_o,
  input logic byte_valid_o,
  input logic sof_o,
  input logic eof_o,
  input logic frame_err_o,
  input logic align_err_o
);
  assert_crs_in_dv_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crs_o |-> rx_dv_o);

  assert_crs_rise_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(crs_o) |-> $rose(rx_dv_o));

  assert_sof_with_byte_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_o |-> byte_valid_o);

  assert_byte_inside_dv_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_o |-> rx_dv_o);

  assert_eof_after_dv_fall_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eof_o |-> (!$past(rx_dv_o) && $past(rx_dv_o, 2)));

  assert_no_byte_at_eof_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eof_o |-> !byte_valid_o);

  assert_align_only_at_eof_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    align_err_o |-> eof_o);

  assert_err_only_at_eof_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_err_o |-> eof_o);
endmodule

bind rmii_rx_decoder rmii_rx_decoder_chk chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .crs_o        (crs_o),
  .rx_dv_o      (rx_dv_o),
  .byte_valid_o (byte_valid_o),
  .sof_o        (sof_o),
  .eof_o        (eof_o),
  .frame_err_o  (frame_err_o),
  .align_err_o  (align_err_o)
);

// File: tb/rmii_rx_decoder_tb_top.sv
`timescale 1ns/1ps
module rmii_rx_decoder_tb_top;
  localparam int MAXD = 512;
  localparam int SAMPLE_J = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       speed_100 = 1'b1;
  logic       crs_dv = 1'b0;
  logic [1:0] rxd = 2'b00;
  logic       rx_er = 1'b0;
  logic       crs, rx_dv, byte_valid, sof, eof, frame_err, align_err;
  logic [7:0] byte_d;

  int n_checks = 0;
  int n_fail = 0;

  logic [1:0] d_a [MAXD];
  logic       c_a [MAXD];
  logic       e_a [MAXD];
  int         n_dib;
  logic [7:0] exp_b [64];

  logic [7:0] got_b [64];
  logic       got_sof [64];
  int         got_n = 0;
  int         eof_n = 0;
  logic       eof_err = 1'b0;
  logic       eof_al = 1'b0;

  always #2.5 clk = ~clk;

  rmii_rx_decoder dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .speed_100_i  (speed_100),
    .crs_dv_i     (crs_dv),
    .rxd_i        (rxd),
    .rx_er_i      (rx_er),
    .crs_o        (crs),
    .rx_dv_o      (rx_dv),
    .byte_o       (byte_d),
    .byte_valid_o (byte_valid),
    .sof_o        (sof),
    .eof_o        (eof),
    .frame_err_o  (frame_err),
    .align_err_o  (align_err)
  );

  always @(negedge clk) begin
    if (byte_valid && got_n < 64) begin
      got_b[got_n]   = byte_d;
      got_sof[got_n] = sof;
      got_n++;
    end
    if (eof) begin
      eof_n++;
      eof_err = frame_err;
      eof_al  = align_err;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [1:0] dd, input logic cc, input logic ee);
    d_a[n_dib] = dd;
    c_a[n_dib] = cc;
    e_a[n_dib] = ee;
    n_dib++;
  endtask

  task automatic push_nib(input logic [3:0] nb, input logic ee);
    push(nb[1:0], 1'b1, ee);
    push(nb[3:2], 1'b1, ee);
  endtask

  // drives the prepared dibit list; sfd_pos/end_pos mark carrier checkpoints
  task automatic play(input bit fast, input int sfd_pos, input int end_pos, input bit tail);
    int hold;
    hold = fast ? 1 : 10;
    for (int i = 0; i < n_dib; i++) begin
      for (int j = 0; j < hold; j++) begin
        @(negedge clk);
        if (j == 0 && i == sfd_pos) begin
          chk(crs == 1'b1, "R3 crs", int'(crs), 1);
          chk(rx_dv == 1'b1, "R3 rx_dv", int'(rx_dv), 1);
        end
        if (j == 0 && i == end_pos) begin
          chk(crs == !tail, "R5 crs", int'(crs), int'(!tail));
          chk(rx_dv == 1'b1, "R5 rx_dv", int'(rx_dv), 1);
        end
        crs_dv = c_a[i];
        rx_er  = e_a[i];
        rxd    = (fast || j == SAMPLE_J) ? d_a[i] : ~d_a[i];
      end
    end
    repeat (fast ? 8 : 24) begin
      @(negedge clk);
      crs_dv = 1'b0;
      rx_er  = 1'b0;
      rxd    = 2'b00;
    end
    chk(rx_dv == 1'b0, "R6 rx_dv after end", int'(rx_dv), 0);
    chk(crs == 1'b0, "R11 crs after end", int'(crs), 0);
  endtask

  task automatic run_frame(input bit fast, input int nzero, input int npre, input int nb,
                           input bit extra, input bit tail, input int er_byte);
    int sfd_pos, end_pos;
    @(negedge clk);
    speed_100 = fast;
    got_n = 0;
    eof_n = 0;
    n_dib = 0;
    repeat (nzero) push(2'b00, 1'b1, 1'b0);
    repeat (npre) push_nib(4'h5, 1'b0);
    sfd_pos = n_dib;
    push_nib(4'hD, 1'b0);
    for (int i = 0; i < nb; i++) begin
      exp_b[i] = 8'((i * 37 + nb * 11 + int'(extra) * 90 + int'(tail) * 7 + 3) & 255);
      push_nib(exp_b[i][3:0], er_byte == i);
      push_nib(exp_b[i][7:4], 1'b0);
    end
    if (extra) push_nib(4'hA, 1'b0);
    end_pos = n_dib;
    if (tail) begin
      c_a[end_pos-2] = 1'b0;
      c_a[end_pos-4] = 1'b0;
    end
    push(2'b00, 1'b0, 1'b0);
    push(2'b00, 1'b0, 1'b0);
    play(fast, sfd_pos, end_pos, tail);
    chk(got_n == nb, "R4 byte count", got_n, nb);
    for (int k = 0; k < nb && k < got_n; k++) begin
      chk(got_b[k] == exp_b[k], fast ? "R7 byte" : "R2 byte", int'(got_b[k]), int'(exp_b[k]));
      chk(got_sof[k] == (k == 0), "R7 sof", int'(got_sof[k]), int'(k == 0));
    end
    chk(eof_n == 1, "R8 eof count", eof_n, 1);
    chk(eof_al == extra, "R9 align", int'(eof_al), int'(extra));
    chk(eof_err == (er_byte >= 0), "R10 err", int'(eof_err), int'(er_byte >= 0));
  endtask

  task automatic run_noframe(input bit fast, input int nzero, input int npre);
    @(negedge clk);
    speed_100 = fast;
    got_n = 0;
    eof_n = 0;
    n_dib = 0;
    repeat (nzero) push(2'b00, 1'b1, 1'b0);
    repeat (npre) push_nib(4'h5, 1'b0);
    push(2'b00, 1'b0, 1'b0);
    push(2'b00, 1'b0, 1'b0);
    play(fast, -1, -1, 1'b0);
    chk(got_n == 0, "R8 no bytes", got_n, 0);
    chk(eof_n == 0, "R8 no eof", eof_n, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk({crs, rx_dv, byte_valid, sof, eof, frame_err, align_err} == 7'b0,
        "R1 reset", int'({crs, rx_dv, byte_valid, sof, eof, frame_err, align_err}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({crs, rx_dv, byte_valid, sof, eof, frame_err, align_err} == 7'b0,
        "R1 after reset", int'({crs, rx_dv, byte_valid, sof, eof, frame_err, align_err}), 0);

    for (int f = 1; f >= 0; f--) begin
      for (int nb = 1; nb <= (f == 1 ? 6 : 3); nb++) begin
        for (int ex = 0; ex < 2; ex++) begin
          for (int tl = 0; tl < 2; tl++) begin
            run_frame(f[0], (nb + tl) % 4, 2 + (nb % 3), nb, ex[0], tl[0],
                      ((nb + ex + tl) % 3 == 0) ? nb - 1 : -1);
          end
        end
      end
      // carrier lost before phase lock, and preamble without delimiter
      run_noframe(f[0], 3, 0);
      run_noframe(f[0], 1, 3);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule